// File: doc/BRIEF.md
# Multi-Channel Timer Register Decoder

This block is the register front end of a small timer unit that has two or three down-counting channels. A simple request strobe with a write flag, a 6-bit byte address and a 32-bit write value reaches it. The block decodes the address inside a 48-byte window. It keeps a one-bit output-control register and a start register that has one run bit per channel, and it forwards every channel access to the register file of the channel that owns the address. Each channel register file holds a reload value, a live count, a control byte, an underflow flag and, on the third channel only, a capture word. Each channel drives its own interrupt line.

Two parameters set the configuration. One chooses between two and three channels. The other chooses whether the output-control register exists. Read data comes from a register, with a valid strobe one cycle after the request. Any access that lands on an unused or unsupported location sets a sticky error flag, and only reset clears it.

Top module: `tmr_bus_decode`

## Requirements
- R1: Address 0x00 holds the output-control bit when HAS_OUTCTL=1. A write stores bit 0 only and drives `out_ctl`, and a read returns that bit zero-extended. When HAS_OUTCTL=0 the address reads 0 and a write leaves `out_ctl` at 0.
- R2: Address 0x04 is the start register. A read returns the full last written 32-bit value. Bit n set lets channel n count, and bit n clear holds the count of channel n steady.
- R3: The decoder tests the bases 0x20, 0x14 and 0x08 from highest to lowest, giving channels 2, 1 and 0. Inside a channel, (address − base) >> 2 picks the register: 0 reload, 1 count, 2 control, 3 capture. A write reaches only the register it addresses.
- R4: Each read request raises `bus_rvalid` for exactly the following cycle, and `bus_rdata` in that cycle holds the addressed value.
- R5: A running channel lowers its count by one on each clock. When it runs at count 0, it loads the reload value and sets the underflow flag, which reads back as control bit 8.
- R6: `chan_irq[n]` is high while channel n has its underflow flag set and control bit 5 (interrupt enable) set. A control write with bit 8 clear clears the flag.
- R7: The capture word exists only on channel 2, at address 0x2C. It stores all 32 bits written to it and reads back as written.
- R8: With THREE_CH=0, any access at 0x20 or above reads 0, changes nothing, and sets the error flag. Start bit 2 has no effect and `chan_irq[2]` stays low.
- R9: An undecoded access reads 0, changes no register, and sets `acc_err`. Undecoded means an address with nonzero low two bits, an address of 0x30 or above, or an unsupported location. Only reset clears `acc_err`.
- R10: After reset, reload and count read 0xFFFFFFFF. Control, capture, start, `out_ctl`, `acc_err` and every interrupt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address inside the window |
| bus_wdata | input | DATA_W | Write value |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | DATA_W | Registered read data |
| chan_irq | output | 3 | One interrupt per channel |
| out_ctl | output | 1 | Output-control bit |
| acc_err | output | 1 | Sticky access-error flag |

## Verification
The bench targets the exact cycle at which a channel started through the start register reaches underflow. If the run bit were taken one stage early or late, the interrupt would rise a cycle off and the count read after stopping would differ by one. It writes one channel and reads the next channel's reload word to find base-comparison mistakes, which would show up as a write landing in the wrong window. It checks the capture word on channel 2 only. A second, two-channel instance without output control drives the upper window and the 0x00 address: a decoder that ignored the configuration would return stored data or raise `chan_irq[2]`, where the correct design returns zeros and sets the error flag.

// File: rtl/tmr_dec_pkg.sv
package tmr_dec_pkg;

   localparam int CH_MAX      = 3;
   localparam int CAP_CHAN    = 2;
   localparam int CTRL_W      = 8;
   localparam int CTRL_IE_BIT = 5;
   localparam int CTRL_UF_BIT = 8;

   localparam int BASE_CH0 = 'h08;
   localparam int BASE_CH1 = 'h14;
   localparam int BASE_CH2 = 'h20;
   localparam int ADR_START  = 'h04;
   localparam int ADR_OUTCTL = 'h00;
   localparam int WIN_END    = 'h30;

   typedef enum logic [1:0] {
      TGT_NONE   = 2'd0,
      TGT_OUTCTL = 2'd1,
      TGT_START  = 2'd2,
      TGT_CHAN   = 2'd3
   } tgt_e;

   typedef enum logic [1:0] {
      CR_RELOAD = 2'd0,
      CR_COUNT  = 2'd1,
      CR_CTRL   = 2'd2,
      CR_CAPT   = 2'd3
   } chreg_e;

   typedef struct packed {
      tgt_e       tgt;
      logic [1:0] chan;
      chreg_e     creg;
      logic       bad;
   } dec_t;

endpackage

// File: rtl/tmr_addr_decode.sv
module tmr_addr_decode
   import tmr_dec_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter bit THREE_CH   = 1'b1,
   parameter bit HAS_OUTCTL = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);

   localparam logic [ADDR_W-1:0] A_END  = ADDR_W'(WIN_END);
   localparam logic [ADDR_W-1:0] A_CH2  = ADDR_W'(BASE_CH2);
   localparam logic [ADDR_W-1:0] A_CH1  = ADDR_W'(BASE_CH1);
   localparam logic [ADDR_W-1:0] A_CH0  = ADDR_W'(BASE_CH0);
   localparam logic [ADDR_W-1:0] A_STRT = ADDR_W'(ADR_START);
   localparam logic [ADDR_W-1:0] A_OCTL = ADDR_W'(ADR_OUTCTL);

   generate
      if (ADDR_W < 6) begin : g_chk_aw
         $error("tmr_addr_decode: ADDR_W must cover the 0x30 window");
      end
   endgenerate

   logic [3:0] sub;
   logic       in_chan;
   logic [1:0] chan;

   // highest base first
   always_comb begin
      in_chan = 1'b0;
      chan    = 2'd0;
      sub     = 4'd0;
      dec     = '{tgt: TGT_NONE, chan: 2'd0, creg: CR_RELOAD, bad: 1'b0};
      if (addr[1:0] != 2'b00 || addr >= A_END) begin
         dec.bad = 1'b1;
      end else if (addr >= A_CH2) begin
         if (THREE_CH) begin
            in_chan = 1'b1;
            chan    = 2'd2;
            sub     = 4'(addr - A_CH2);
         end else begin
            dec.bad = 1'b1;
         end
      end else if (addr >= A_CH1) begin
         in_chan = 1'b1;
         chan    = 2'd1;
         sub     = 4'(addr - A_CH1);
      end else if (addr >= A_CH0) begin
         in_chan = 1'b1;
         chan    = 2'd0;
         sub     = 4'(addr - A_CH0);
      end else if (addr == A_STRT) begin
         dec.tgt = TGT_START;
      end else if (addr == A_OCTL && HAS_OUTCTL) begin
         dec.tgt = TGT_OUTCTL;
      end else begin
         dec.bad = 1'b1;
      end

      if (in_chan) begin
         if (chreg_e'(sub[3:2]) == CR_CAPT && chan != 2'(CAP_CHAN)) begin
            dec.bad = 1'b1;
         end else begin
            dec.tgt  = TGT_CHAN;
            dec.chan = chan;
            dec.creg = chreg_e'(sub[3:2]);
         end
      end
   end

endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
   import tmr_dec_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit HAS_CAP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  chreg_e            creg,
   input  logic [DATA_W-1:0] wdata,
   input  logic              run,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);

   generate
      if (DATA_W < CTRL_UF_BIT + 1) begin : g_chk_dw
         $error("tmr_chan_regs: DATA_W too narrow for the control layout");
      end
   endgenerate

   logic [DATA_W-1:0] reload_q;
   logic [DATA_W-1:0] cnt_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic              uf_q;
   logic [DATA_W-1:0] cap_q;

   // counting first, then a software write overrides in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '1;
         cnt_q    <= '1;
         ctrl_q   <= '0;
         uf_q     <= 1'b0;
      end else begin
         if (run) begin
            if (cnt_q == '0) begin
               cnt_q <= reload_q;
               uf_q  <= 1'b1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
         if (wr_en) begin
            case (creg)
               CR_RELOAD: reload_q <= wdata;
               CR_COUNT:  cnt_q    <= wdata;
               CR_CTRL: begin
                  ctrl_q <= wdata[CTRL_W-1:0];
                  if (!wdata[CTRL_UF_BIT]) uf_q <= 1'b0;
               end
               default: ;
            endcase
         end
      end
   end

   generate
      if (HAS_CAP) begin : g_cap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        cap_q <= '0;
            else if (wr_en && creg == CR_CAPT) cap_q <= wdata;
         end
      end else begin : g_nocap
         assign cap_q = '0;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      case (creg)
         CR_RELOAD: rdata = reload_q;
         CR_COUNT:  rdata = cnt_q;
         CR_CTRL: begin
            rdata[CTRL_W-1:0]  = ctrl_q;
            rdata[CTRL_UF_BIT] = uf_q;
         end
         CR_CAPT:   rdata = cap_q;
         default:   rdata = '0;
      endcase
   end

   assign irq = uf_q & ctrl_q[CTRL_IE_BIT];

   a_r5_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt_q == '0 && !(wr_en && creg == CR_COUNT)) |=> (cnt_q == $past(reload_q) && uf_q));

   a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt_q != '0 && !(wr_en && creg == CR_COUNT)) |=> (cnt_q == $past(cnt_q) - 1'b1));

   a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_en) |=> $stable(cnt_q));

   a_r6_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && creg == CR_CTRL && !wdata[CTRL_UF_BIT]) |=> !irq);

endmodule

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
   import tmr_dec_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int DATA_W     = 32,
   parameter bit THREE_CH   = 1'b1,
   parameter bit HAS_OUTCTL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              bus_rvalid,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [2:0]        chan_irq,
   output logic              out_ctl,
   output logic              acc_err
);

   localparam int NCH = THREE_CH ? 3 : 2;

   generate
      if (DATA_W < CH_MAX) begin : g_chk_dw
         $error("tmr_bus_decode: DATA_W must hold one run bit per channel");
      end
   endgenerate

   dec_t              dec;
   logic [DATA_W-1:0] start_q;
   logic              outctl_q;
   logic              err_q;
   logic              rvalid_q;
   logic [DATA_W-1:0] rdata_q;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] ch_rd [CH_MAX];
   logic [CH_MAX-1:0] irq_w;
   logic              wr_hit;

   tmr_addr_decode #(
      .ADDR_W     (ADDR_W),
      .THREE_CH   (THREE_CH),
      .HAS_OUTCTL (HAS_OUTCTL)
   ) u_dec (
      .addr (bus_addr),
      .dec  (dec)
   );

   assign wr_hit = bus_req & bus_wr;

   generate
      for (genvar g = 0; g < CH_MAX; g++) begin : g_ch
         if (g < NCH) begin : g_on
            tmr_chan_regs #(
               .DATA_W  (DATA_W),
               .HAS_CAP (g == CAP_CHAN)
            ) u_chan (
               .clk   (clk),
               .rst_n (rst_n),
               .wr_en (wr_hit && dec.tgt == TGT_CHAN && dec.chan == 2'(g)),
               .creg  (dec.creg),
               .wdata (bus_wdata),
               .run   (start_q[g]),
               .rdata (ch_rd[g]),
               .irq   (irq_w[g])
            );
         end else begin : g_off
            assign ch_rd[g] = '0;
            assign irq_w[g] = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q  <= '0;
         outctl_q <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         if (wr_hit && dec.tgt == TGT_START)  start_q  <= bus_wdata;
         if (wr_hit && dec.tgt == TGT_OUTCTL) outctl_q <= bus_wdata[0];
         if (bus_req && dec.bad)              err_q    <= 1'b1;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (dec.tgt)
         TGT_OUTCTL: rd_mux[0] = outctl_q;
         TGT_START:  rd_mux    = start_q;
         TGT_CHAN: begin
            case (dec.chan)
               2'd0:    rd_mux = ch_rd[0];
               2'd1:    rd_mux = ch_rd[1];
               2'd2:    rd_mux = ch_rd[2];
               default: rd_mux = '0;
            endcase
         end
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         rvalid_q <= bus_req & ~bus_wr;
         if (bus_req && !bus_wr) rdata_q <= rd_mux;
      end
   end

   assign bus_rvalid = rvalid_q;
   assign bus_rdata  = rdata_q;
   assign chan_irq   = irq_w;
   assign out_ctl    = outctl_q;
   assign acc_err    = err_q;

   a_r4_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_wr) |=> bus_rvalid);

   a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && !bus_wr) |=> !bus_rvalid);

   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |=> acc_err);

   a_r9_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_wr && dec.bad) |=> (acc_err && bus_rdata == '0));

   a_r1_outctl_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && bus_addr == '0 && HAS_OUTCTL) |=> (out_ctl == $past(bus_wdata[0])));

   a_r2_start_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && bus_addr == ADDR_W'(ADR_START)) |=> (start_q == $past(bus_wdata)));

endmodule

// File: tb/test_tmr_bus_decode.sv
module test_tmr_bus_decode;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   // instance A: three channels with output control
   logic        a_req = 0, a_wr = 0;
   logic [5:0]  a_addr = 0;
   logic [31:0] a_wdata = 0;
   logic        a_rv;
   logic [31:0] a_rd;
   logic [2:0]  a_irq;
   logic        a_oc, a_err;

   // instance B: two channels, no output control
   logic        b_req = 0, b_wr = 0;
   logic [5:0]  b_addr = 0;
   logic [31:0] b_wdata = 0;
   logic        b_rv;
   logic [31:0] b_rd;
   logic [2:0]  b_irq;
   logic        b_oc, b_err;

   tmr_bus_decode i_tmr_bus_decode (
      .clk(clk), .rst_n(rst_n), .bus_req(a_req), .bus_wr(a_wr),
      .bus_addr(a_addr), .bus_wdata(a_wdata), .bus_rvalid(a_rv),
      .bus_rdata(a_rd), .chan_irq(a_irq), .out_ctl(a_oc), .acc_err(a_err));

   tmr_bus_decode #(.THREE_CH(1'b0), .HAS_OUTCTL(1'b0)) i_tmr_bus_decode_two (
      .clk(clk), .rst_n(rst_n), .bus_req(b_req), .bus_wr(b_wr),
      .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rvalid(b_rv),
      .bus_rdata(b_rd), .chan_irq(b_irq), .out_ctl(b_oc), .acc_err(b_err));

   int checks = 0;
   int fails  = 0;
   logic [31:0] qa_val[$];
   string       qa_tag[$];
   logic [31:0] qb_val[$];
   string       qb_tag[$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: called just after a falling edge, returns at the next one
   task automatic acc(input bit to_b, input bit wr, input logic [5:0] ad,
                      input logic [31:0] d, input logic [31:0] exp, input string tag);
      if (!to_b) begin
         a_req = 1; a_wr = wr; a_addr = ad; a_wdata = d;
         if (!wr) begin qa_val.push_back(exp); qa_tag.push_back(tag); end
      end else begin
         b_req = 1; b_wr = wr; b_addr = ad; b_wdata = d;
         if (!wr) begin qb_val.push_back(exp); qb_tag.push_back(tag); end
      end
      @(negedge clk);
      a_req = 0; a_wr = 0;
      b_req = 0; b_wr = 0;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (a_rv) begin
            if (qa_val.size() == 0) chk("R4 unexpected read valid A", 32'd1, 32'd0);
            else chk(qa_tag.pop_front(), a_rd, qa_val.pop_front());
         end
         if (b_rv) begin
            if (qb_val.size() == 0) chk("R4 unexpected read valid B", 32'd1, 32'd0);
            else chk(qb_tag.pop_front(), b_rd, qb_val.pop_front());
         end
      end
   end

   initial begin
      int cyc = 0;
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      chk("R10 irq A", {29'd0, a_irq}, 0);
      chk("R10 err A", {31'd0, a_err}, 0);
      chk("R10 out_ctl A", {31'd0, a_oc}, 0);
      acc(0, 0, 6'h08, 0, 32'hFFFF_FFFF, "R10 ch0 reload");
      acc(0, 0, 6'h0C, 0, 32'hFFFF_FFFF, "R10 ch0 count");
      acc(0, 0, 6'h10, 0, 32'h0, "R10 ch0 control");
      acc(0, 0, 6'h04, 0, 32'h0, "R10 start");
      acc(0, 0, 6'h2C, 0, 32'h0, "R10 capture");

      // R1 output control
      acc(0, 1, 6'h00, 32'hFF, 0, "");
      acc(0, 0, 6'h00, 0, 32'h1, "R1 outctl readback");
      chk("R1 out_ctl pin", {31'd0, a_oc}, 1);

      // R2 start register full readback
      acc(0, 1, 6'h04, 32'hA5A5_0000, 0, "");
      acc(0, 0, 6'h04, 0, 32'hA5A5_0000, "R2 start readback");
      acc(0, 1, 6'h04, 32'h0, 0, "");

      // R3 window routing, R7 capture
      acc(0, 1, 6'h14, 32'h1234, 0, "");
      acc(0, 0, 6'h14, 0, 32'h1234, "R3 ch1 reload");
      acc(0, 0, 6'h08, 0, 32'hFFFF_FFFF, "R3 ch0 untouched");
      acc(0, 1, 6'h2C, 32'hCAFE_F00D, 0, "");
      acc(0, 0, 6'h2C, 0, 32'hCAFE_F00D, "R7 capture readback");
      acc(0, 0, 6'h20, 0, 32'hFFFF_FFFF, "R3 ch2 reload untouched");

      // R5/R6 counting on channel 0
      acc(0, 1, 6'h08, 32'd3, 0, "");
      acc(0, 1, 6'h0C, 32'd2, 0, "");
      acc(0, 1, 6'h10, 32'h20, 0, "");
      acc(0, 1, 6'h04, 32'h1, 0, "");
      @(negedge clk); chk("R5 irq after 1st tick", {29'd0, a_irq}, 0);
      @(negedge clk); chk("R5 irq after 2nd tick", {29'd0, a_irq}, 0);
      @(negedge clk); chk("R6 irq at underflow", {29'd0, a_irq}, 3'b001);
      acc(0, 1, 6'h04, 32'h0, 0, "");
      acc(0, 0, 6'h0C, 0, 32'd2, "R5 count after reload and one tick");
      acc(0, 0, 6'h0C, 0, 32'd2, "R2 count held when stopped");
      acc(0, 0, 6'h10, 0, 32'h120, "R5 underflow flag bit 8");
      acc(0, 1, 6'h10, 32'h20, 0, "");
      chk("R6 irq cleared", {29'd0, a_irq}, 0);
      acc(0, 0, 6'h10, 0, 32'h20, "R6 control after clear");

      // R2 channel 2 run bit
      acc(0, 1, 6'h20, 32'd5, 0, "");
      acc(0, 1, 6'h28, 32'h20, 0, "");
      acc(0, 1, 6'h24, 32'd0, 0, "");
      acc(0, 1, 6'h04, 32'h4, 0, "");
      repeat (3) @(negedge clk);
      chk("R2 ch2 run bit irq", {29'd0, a_irq}, 3'b100);
      acc(0, 1, 6'h04, 32'h0, 0, "");

      // R9 undecoded
      chk("R9 err before bad access", {31'd0, a_err}, 0);
      acc(0, 0, 6'h05, 0, 32'h0, "R9 unaligned read");
      chk("R9 err set", {31'd0, a_err}, 1);
      acc(0, 1, 6'h38, 32'hFFFF_FFFF, 0, "");
      acc(0, 0, 6'h38, 0, 32'h0, "R9 beyond window read");
      acc(0, 0, 6'h04, 0, 32'h0, "R9 start untouched by bad write");
      repeat (2) @(negedge clk);
      chk("R9 err sticky", {31'd0, a_err}, 1);

      // R8 two-channel configuration
      chk("R8 err initial B", {31'd0, b_err}, 0);
      acc(1, 1, 6'h04, 32'h7, 0, "");
      acc(1, 0, 6'h04, 0, 32'h7, "R8 start readback two-channel");
      acc(1, 1, 6'h20, 32'h1, 0, "");
      acc(1, 1, 6'h28, 32'h20, 0, "");
      acc(1, 0, 6'h20, 0, 32'h0, "R8 upper window reads zero");
      chk("R8 err set B", {31'd0, b_err}, 1);
      repeat (4) @(negedge clk);
      chk("R8 no ch2 irq", {29'd0, b_irq}, 0);
      acc(1, 1, 6'h04, 32'h0, 0, "");

      // R1 without output control
      acc(1, 1, 6'h00, 32'h1, 0, "");
      acc(1, 0, 6'h00, 0, 32'h0, "R1 absent outctl reads zero");
      chk("R1 absent out_ctl pin", {31'd0, b_oc}, 0);

      @(negedge clk);
      chk("R4 scoreboard A drained", qa_val.size(), 0);
      chk("R4 scoreboard B drained", qb_val.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule